// File: doc/BRIEF.md
# Pipelined Studio-Range YCbCr to RGB Converter

This block turns one studio-range luma/chroma sample into one full-range red, green, blue triple on every clock. Luma carries a black level of 16 and the two chroma components are centred on 128. The block removes those offsets, multiplies by a fixed colour matrix held as signed fixed-point constants, rounds to the nearest integer, and saturates each channel to the output range.

The arithmetic runs through three register stages: offset removal, then products, then sum with rounding and clamp. A result therefore leaves a fixed three clocks after its sample is taken, and a new sample can enter on every clock. A valid flag travels alongside the data through a separate three-stage chain. The synchronous reset acts on that chain alone, so the data registers keep converting through a reset.

Top module: `ycc2rgb_pipe`

## Requirements
- R1: For every input triple each output lies within 2 LSB of the clamped real-valued result, where R = 1.164(Y-16) + 1.596(Cr-128), G = 1.164(Y-16) - 0.813(Cr-128) - 0.392(Cb-128) and B = 1.164(Y-16) + 2.017(Cb-128).
- R2: For an in-range channel, the result is rounded, so the output lies within 1 LSB of the exact real value.
- R3: A channel whose exact value is below zero outputs 0.
- R4: A channel whose exact value is above 255 outputs 255.
- R5: A sample taken at a rising edge appears on the outputs right after the third rising edge that follows its setup, that is three clocks of latency.
- R6: A new sample is accepted on every clock with no gaps, and each output matches its own sample when neighbours differ.
- R7: The output valid equals the input valid from three clocks earlier.
- R8: While the active-low reset is sampled low, the valid chain is cleared, so the output valid is 0 after that edge and stays 0 until fresh valid samples come through. The data path is not reset and keeps producing correct conversions during reset.
- R9: When Cb = 128 and Cr = 128 the three outputs are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, acts on the valid chain only |
| vld_i | input | 1 | Input sample valid |
| y_i | input | 8 | Luma, unsigned, studio range |
| cb_i | input | 8 | Blue-difference chroma, unsigned, centred on 128 |
| cr_i | input | 8 | Red-difference chroma, unsigned, centred on 128 |
| vld_o | output | 1 | Output valid, delayed three clocks |
| r_o | output | 8 | Red, unsigned, 0 to 255 |
| g_o | output | 8 | Green, unsigned, 0 to 255 |
| b_o | output | 8 | Blue, unsigned, 0 to 255 |

## Verification
In one sample, one channel can saturate high while another saturates low, or a clamped channel can sit beside a rounded in-range one. The bench produces this with a luma, Cb and Cr grid that includes the extremes 0 and 255 on every axis, such as (0, 0, 255) and (255, 0, 0). It judges each channel on its own against a clamped real model. A reset applied in the middle of a valid stream likewise lands in the same cycle as live conversions. The bench checks that the valid output drops while the data outputs keep matching the model.

// File: rtl/ycc2rgb_pkg.sv
// Package: shared fixed-point helpers for the YCbCr to RGB pipeline.
// Assumes coefficients are given in thousandths and quantised with rounding.
package ycc2rgb_pkg;

    // Quantise a coefficient given in thousandths to FRAC fractional bits, rounded.
    function automatic int fx_coef(input int milli, input int frac);
        return (milli * (1 << frac) + 500) / 1000;
    endfunction

    // Matrix entries in thousandths.
    localparam int K_LUMA_M   = 1164;
    localparam int K_R_CR_M   = 1596;
    localparam int K_G_CR_M   = 813;
    localparam int K_G_CB_M   = 392;
    localparam int K_B_CB_M   = 2017;

endpackage

// File: rtl/ycc_offset_stage.sv
// Stage 1: removes the black level from luma and the mid-scale bias from
// both chroma components, and registers the signed results.
// Assumes DW >= 8; the black level scales with DW.
module ycc_offset_stage #(
    parameter int DW = 8,
    parameter int OW = DW + 2
) (
    input  logic                 clk,
    input  logic [DW-1:0]        y_i,
    input  logic [DW-1:0]        cb_i,
    input  logic [DW-1:0]        cr_i,
    output logic signed [OW-1:0] y_off_o,
    output logic signed [OW-1:0] cb_off_o,
    output logic signed [OW-1:0] cr_off_o
);
    localparam logic signed [OW-1:0] LUMA_BLACK = OW'(16 << (DW - 8));
    localparam logic signed [OW-1:0] CHROMA_MID = OW'(1 << (DW - 1));

    logic signed [OW-1:0] y_ext, cb_ext, cr_ext;

    // Zero-extend the unsigned inputs into the signed working width.
    always_comb begin
        y_ext  = $signed({{(OW-DW){1'b0}}, y_i});
        cb_ext = $signed({{(OW-DW){1'b0}}, cb_i});
        cr_ext = $signed({{(OW-DW){1'b0}}, cr_i});
    end

    // Register the offset-removed components.
    always_ff @(posedge clk) begin
        y_off_o  <= y_ext  - LUMA_BLACK;
        cb_off_o <= cb_ext - CHROMA_MID;
        cr_off_o <= cr_ext - CHROMA_MID;
    end
endmodule

// File: rtl/ycc_product_stage.sv
// Stage 2: forms the five matrix products from the offset components.
// Negative matrix entries are folded into their constants so that the
// following stage only adds. Assumes every coefficient magnitude is below 4.
module ycc_product_stage #(
    parameter int OW   = 10,
    parameter int FRAC = 12,
    parameter int CW   = FRAC + 3,
    parameter int PW   = OW + CW
) (
    input  logic                 clk,
    input  logic signed [OW-1:0] y_off_i,
    input  logic signed [OW-1:0] cb_off_i,
    input  logic signed [OW-1:0] cr_off_i,
    output logic signed [PW-1:0] p_luma_o,
    output logic signed [PW-1:0] p_r_cr_o,
    output logic signed [PW-1:0] p_g_cr_o,
    output logic signed [PW-1:0] p_g_cb_o,
    output logic signed [PW-1:0] p_b_cb_o
);
    import ycc2rgb_pkg::*;

    localparam logic signed [CW-1:0] C_LUMA = CW'( fx_coef(K_LUMA_M, FRAC));
    localparam logic signed [CW-1:0] C_R_CR = CW'( fx_coef(K_R_CR_M, FRAC));
    localparam logic signed [CW-1:0] C_G_CR = CW'(-fx_coef(K_G_CR_M, FRAC));
    localparam logic signed [CW-1:0] C_G_CB = CW'(-fx_coef(K_G_CB_M, FRAC));
    localparam logic signed [CW-1:0] C_B_CB = CW'( fx_coef(K_B_CB_M, FRAC));

    // Register the signed products at full precision.
    always_ff @(posedge clk) begin
        p_luma_o <= PW'(C_LUMA * y_off_i);
        p_r_cr_o <= PW'(C_R_CR * cr_off_i);
        p_g_cr_o <= PW'(C_G_CR * cr_off_i);
        p_g_cb_o <= PW'(C_G_CB * cb_off_i);
        p_b_cb_o <= PW'(C_B_CB * cb_off_i);
    end
endmodule

// File: rtl/ycc_sum_clamp.sv
// Stage 3, one channel: adds three signed products, rounds half up at the
// binary point, saturates to 0..2^DW-1 and registers the pixel.
// Assumes the sum width has headroom beyond the product width.
module ycc_sum_clamp #(
    parameter int DW   = 8,
    parameter int FRAC = 12,
    parameter int PW   = 25,
    parameter int SW   = PW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [PW-1:0] term0_i,
    input  logic signed [PW-1:0] term1_i,
    input  logic signed [PW-1:0] term2_i,
    output logic [DW-1:0]        pix_o
);
    localparam logic signed [SW-1:0] HALF_LSB = SW'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] PIX_MAX  = SW'((1 << DW) - 1);

    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] whole;
    logic [DW-1:0]        sat;

    // Sum with a rounding bias, then drop the fraction.
    always_comb begin
        acc   = SW'(term0_i) + SW'(term1_i) + SW'(term2_i) + HALF_LSB;
        whole = acc >>> FRAC;
    end

    // Saturate the rounded integer into the pixel range.
    always_comb begin
        if (whole < 0)
            sat = '0;
        else if (whole > PIX_MAX)
            sat = '1;
        else
            sat = whole[DW-1:0];
    end

    // Register the channel result.
    always_ff @(posedge clk) begin
        pix_o <= sat;
    end

    // R3
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc < 0) |=> (pix_o == '0));

    // R4
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (whole > PIX_MAX) |=> (pix_o == '1));
endmodule

// File: rtl/ycc2rgb_pipe.sv
// Top: three-stage YCbCr to RGB conversion with a valid flag that follows
// the data. Reset clears the valid chain only; data registers are free-running.
// Assumes studio-range inputs; outputs are full-range and saturated.
module ycc2rgb_pipe #(
    parameter int DW   = 8,
    parameter int FRAC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] cb_i,
    input  logic [DW-1:0] cr_i,
    output logic          vld_o,
    output logic [DW-1:0] r_o,
    output logic [DW-1:0] g_o,
    output logic [DW-1:0] b_o
);
    localparam int OW    = DW + 2;
    localparam int CW    = FRAC + 3;
    localparam int PW    = OW + CW;
    localparam int SW    = PW + 2;
    localparam int LAT   = 3;
    localparam int NCH   = 3;

    logic signed [OW-1:0] y_off, cb_off, cr_off;
    logic signed [PW-1:0] p_luma, p_r_cr, p_g_cr, p_g_cb, p_b_cb;
    logic signed [PW-1:0] chan_t1 [NCH];
    logic signed [PW-1:0] chan_t2 [NCH];
    logic [DW-1:0]        chan_pix [NCH];
    logic [LAT-1:0]       vld_sr;

    ycc_offset_stage #(.DW(DW), .OW(OW)) off_i (
        .clk      (clk),
        .y_i      (y_i),
        .cb_i     (cb_i),
        .cr_i     (cr_i),
        .y_off_o  (y_off),
        .cb_off_o (cb_off),
        .cr_off_o (cr_off)
    );

    ycc_product_stage #(.OW(OW), .FRAC(FRAC), .CW(CW), .PW(PW)) mul_i (
        .clk      (clk),
        .y_off_i  (y_off),
        .cb_off_i (cb_off),
        .cr_off_i (cr_off),
        .p_luma_o (p_luma),
        .p_r_cr_o (p_r_cr),
        .p_g_cr_o (p_g_cr),
        .p_g_cb_o (p_g_cb),
        .p_b_cb_o (p_b_cb)
    );

    // Route the chroma products of each channel; unused slots are zero.
    always_comb begin
        chan_t1[0] = p_r_cr;  chan_t2[0] = '0;
        chan_t1[1] = p_g_cr;  chan_t2[1] = p_g_cb;
        chan_t1[2] = p_b_cb;  chan_t2[2] = '0;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ycc_sum_clamp #(.DW(DW), .FRAC(FRAC), .PW(PW), .SW(SW)) sc_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .term0_i (p_luma),
            .term1_i (chan_t1[ch]),
            .term2_i (chan_t2[ch]),
            .pix_o   (chan_pix[ch])
        );
    end

    assign r_o = chan_pix[0];
    assign g_o = chan_pix[1];
    assign b_o = chan_pix[2];

    // Shift the valid flag in step with the data stages.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_sr <= '0;
        else
            vld_sr <= {vld_sr[LAT-2:0], vld_i};
    end

    assign vld_o = vld_sr[LAT-1];

    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> ##3 vld_o);

    // R7
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |-> ##3 !vld_o);

    // R8
    vld_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !vld_o);

    // R9
    neutral_grey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_i == DW'(1 << (DW - 1)) && cr_i == DW'(1 << (DW - 1)))
        |-> ##3 (r_o == g_o && g_o == b_o));
endmodule

// File: tb/ycc2rgb_pipe_tb.sv
`timescale 1ns/1ps
module ycc2rgb_pipe_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld_i = 1'b0;
    logic [7:0] y_i = 8'd0, cb_i = 8'd128, cr_i = 8'd128;
    logic       vld_o;
    logic [7:0] r_o, g_o, b_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Four-slot history: expected values per drive cycle.
    real h_er [4], h_eg [4], h_eb [4];
    real h_rr [4], h_rg [4], h_rb [4];
    bit  h_v  [4], h_rst [4], h_grey [4];

    always #2 clk = ~clk;

    ycc2rgb_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i),
        .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
        .vld_o(vld_o), .r_o(r_o), .g_o(g_o), .b_o(b_o)
    );

    function automatic real clampr(input real v);
        if (v < 0.0) return 0.0;
        if (v > 255.0) return 255.0;
        return v;
    endfunction

    task automatic chk_chan(input string nm, input int got, input real raw);
        real e, d;
        string tag;
        e = clampr(raw);
        d = real'(got) - e;
        if (raw < 0.0) tag = "R3";
        else if (raw > 255.0) tag = "R4";
        else tag = "R2";
        checks++;
        if (d > 1.0 || d < -1.0) begin
            fails++;
            $display("FAIL %s (R1/R5/R6) ch %s: got %0d expected %f", tag, nm, got, e);
        end
    endtask

    // One clock: check outputs for the sample driven three cycles ago, then drive.
    task automatic step(input int y, input int cb, input int cr, input bit v, input bit r);
        real ry, rcb, rcr;
        int s, s1, s2, k;
        bit ev;
        @(negedge clk);
        if (cyc >= 3) begin
            s  = (cyc - 3) & 3;
            s1 = (cyc - 2) & 3;
            s2 = (cyc - 1) & 3;
            ev = h_v[s] && h_rst[s] && h_rst[s1] && h_rst[s2];
            checks++;
            if (vld_o !== ev) begin
                fails++;
                $display("FAIL R7/R8 valid: got %0b expected %0b", vld_o, ev);
            end
            chk_chan("R", int'(r_o), h_rr[s]);
            chk_chan("G", int'(g_o), h_rg[s]);
            chk_chan("B", int'(b_o), h_rb[s]);
            if (h_grey[s]) begin
                checks++;
                if (!(r_o == g_o && g_o == b_o)) begin
                    fails++;
                    $display("FAIL R9 grey: got %0d/%0d/%0d expected equal", r_o, g_o, b_o);
                end
            end
        end
        y_i = 8'(y); cb_i = 8'(cb); cr_i = 8'(cr);
        vld_i = v; rst_n = r;
        k = cyc & 3;
        ry  = real'(y) - 16.0;
        rcb = real'(cb) - 128.0;
        rcr = real'(cr) - 128.0;
        h_rr[k] = 1.164 * ry + 1.596 * rcr;
        h_rg[k] = 1.164 * ry - 0.813 * rcr - 0.392 * rcb;
        h_rb[k] = 1.164 * ry + 2.017 * rcb;
        h_er[k] = clampr(h_rr[k]);
        h_eg[k] = clampr(h_rg[k]);
        h_eb[k] = clampr(h_rb[k]);
        h_v[k] = v; h_rst[k] = r;
        h_grey[k] = (cb == 128 && cr == 128);
        cyc++;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        // Reset phase: valid must stay low (R8), data already converts.
        for (int i = 0; i < 5; i++) step(16, 128, 128, 1'b1, 1'b0);
        @(negedge clk);
        checks++;
        if (vld_o !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset state: got %0b expected 0", vld_o);
        end
        // Corners called out by R1, R3, R4.
        step(255, 255, 255, 1'b1, 1'b1);
        step(255, 0, 0, 1'b1, 1'b1);
        step(0, 0, 255, 1'b1, 1'b1);
        step(0, 255, 0, 1'b1, 1'b1);
        // Coarse 3D grid streamed back to back with a gapped valid (R1, R6, R7).
        n = 0;
        for (int y = 0; y <= 255; y += 15)
            for (int cb = 0; cb <= 255; cb += 15)
                for (int cr = 0; cr <= 255; cr += 15) begin
                    step(y, cb, cr, (n % 5) != 2, 1'b1);
                    n++;
                end
        // Full luma sweep with neutral chroma (R9, R2).
        for (int y = 0; y < 256; y++) step(y, 128, 128, 1'b1, 1'b1);
        // Full Cr sweep at high luma, full Cb sweep at low luma (R3, R4).
        for (int c = 0; c < 256; c++) step(235, 16, c, c[0], 1'b1);
        for (int c = 0; c < 256; c++) step(16, c, 240, 1'b1, 1'b1);
        // Reset in the middle of a valid stream (R8): data keeps converting.
        for (int i = 0; i < 3; i++) step(100 + i, 60, 200, 1'b1, 1'b1);
        step(200, 30, 90, 1'b1, 1'b0);
        step(50, 220, 10, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(80 + 20 * i, 255 - 30 * i, 30 * i, 1'b1, 1'b1);
        // Flush.
        for (int i = 0; i < 4; i++) step(16, 128, 128, 1'b0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule